// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block holds the program counter of a 32-bit processor with fixed-width instructions and works out which address comes next. On each cycle where the valid strobe is high, it decodes the instruction word together with the register operand values it is given. Those operands are rA, rB and the current contents of the link register r31. It then loads the PC register with one of four values: the sequential address, a PC-relative branch target, an absolute target inside the current 256 MiB region, or a register value.

The same cycle also produces a link-register write: a write enable, a register index and a value. Calls use it to save the return address, and the next-PC read instruction uses it to copy the return address into a general register. The write enable, index and value depend only on the current inputs and on the PC register, so the register file can capture them at the same clock edge as the PC update.

The PC register itself is the current PC and is visible on `pc_o`. Instructions that do not transfer control advance the PC by 4.

Top module: `ctl_xfer_unit`

## Requirements
- R1: After reset `pc_o` equals the parameter `RESET_ADDR`, and `link_we_o` is low while `valid_i` is low.
- R2: While `valid_i` is low, `pc_o` keeps its value and `link_we_o` stays low, whatever the instruction word is.
- R3: With `valid_i` high, an instruction that does not transfer control sets the next PC to PC+4 and writes no link. Opcode means bits [5:0]; any opcode outside the set listed in R4 to R7, and other than 0x3A, counts as such an instruction.
- R4: Opcode 0x01 (jump) and opcode 0x00 (call) set the next PC to {PC[31:28], instr[31:6], 2'b00}.
- R5: A call (opcode 0x00) raises `link_we_o` with `link_idx_o` = 31 and `link_val_o` = PC+4.
- R6: Opcode 0x06 (branch always) sets the next PC to PC+4 + (sign-extended instr[21:6] with its two low bits cleared).
- R7: Conditional branches compare rA (operand from field bits [31:27]) with rB (operand from field bits [26:22]). The opcodes are 0x0E signed >=, 0x16 signed <, 0x1E not equal, 0x26 equal, 0x2E unsigned >= and 0x36 unsigned <. When the comparison holds, the next PC is the R6 target; otherwise it is PC+4. None of them writes a link.
- R8: With opcode 0x3A, the extended opcode is bits [16:11]. Extended opcode 0x05 (return) sets the next PC to the value on `r31_val_i`, and 0x0D (register jump) sets it to `ra_val_i`. Neither writes a link.
- R9: Extended opcode 0x1D (register call) sets the next PC to `ra_val_i` and writes PC+4 to r31. The jump target is the rA value supplied in that cycle, before the link write, which also holds when field A is 31.
- R10: Extended opcode 0x1C (next-PC read) writes PC+4 to the register named by bits [21:17] and advances the PC by 4. No link write is ever raised with index 0.
- R11: Any other extended opcode under 0x3A advances the PC by 4 and writes no link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| ra_val_i | input | 32 | Value of register named by field A |
| rb_val_i | input | 32 | Value of register named by field B |
| r31_val_i | input | 32 | Current value of link register r31 |
| pc_o | output | 32 | Registered program counter (current PC) |
| link_we_o | output | 1 | Link/result register write enable |
| link_idx_o | output | 5 | Register index written |
| link_val_o | output | 32 | Value written (PC+4) |

## Verification
A wrong PC register shows up on `pc_o` one edge after the faulty instruction. Every later relative branch, region jump and link value then inherits the error, so the reference model flags it on the next sample at the latest. A wrong decode of the link fields shows up in the same cycle on `link_we_o`, `link_idx_o` or `link_val_o`, before the clock edge. Separating signed from unsigned comparisons takes operands whose sign bit is set; the register call case needs A equal to 31.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;

    localparam int WORD_W  = 32;
    localparam int REG_W   = 5;
    localparam int OP_W    = 6;
    localparam int IMM16_W = 16;
    localparam int IMM26_W = 26;
    localparam int REGION_W = 4;
    localparam logic [REG_W-1:0] LINK_REG = 5'd31;

    localparam logic [OP_W-1:0] OP_CALL  = 6'h00;
    localparam logic [OP_W-1:0] OP_JUMP  = 6'h01;
    localparam logic [OP_W-1:0] OP_BRA   = 6'h06;
    localparam logic [OP_W-1:0] OP_BGE   = 6'h0E;
    localparam logic [OP_W-1:0] OP_BLT   = 6'h16;
    localparam logic [OP_W-1:0] OP_BNE   = 6'h1E;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'h26;
    localparam logic [OP_W-1:0] OP_BGEU  = 6'h2E;
    localparam logic [OP_W-1:0] OP_BLTU  = 6'h36;
    localparam logic [OP_W-1:0] OP_RTYPE = 6'h3A;

    localparam logic [OP_W-1:0] XOP_RET  = 6'h05;
    localparam logic [OP_W-1:0] XOP_JMPR = 6'h0D;
    localparam logic [OP_W-1:0] XOP_RDPC = 6'h1C;
    localparam logic [OP_W-1:0] XOP_CALR = 6'h1D;

    typedef enum logic [2:0] {
        K_SEQ, K_ABS, K_REL, K_COND, K_RET, K_REG
    } xfer_kind_e;

    typedef enum logic [2:0] {
        C_GE, C_LT, C_NE, C_EQ, C_GEU, C_LTU
    } cmp_sel_e;

    typedef struct packed {
        xfer_kind_e       kind;
        cmp_sel_e         cmp;
        logic             link;
        logic [REG_W-1:0] link_idx;
    } xfer_dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
    } xfer_state_t;

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_xfer_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic [OP_W-1:0]  xop_i,
    input  logic [REG_W-1:0] c_i,
    output xfer_dec_t        dec_o
);

    always_comb begin
        dec_o = '{kind: K_SEQ, cmp: C_EQ, link: 1'b0, link_idx: '0};
        case (op_i)
            OP_CALL: begin
                dec_o.kind     = K_ABS;
                dec_o.link     = 1'b1;
                dec_o.link_idx = LINK_REG;
            end
            OP_JUMP: dec_o.kind = K_ABS;
            OP_BRA:  dec_o.kind = K_REL;
            OP_BGE:  begin dec_o.kind = K_COND; dec_o.cmp = C_GE;  end
            OP_BLT:  begin dec_o.kind = K_COND; dec_o.cmp = C_LT;  end
            OP_BNE:  begin dec_o.kind = K_COND; dec_o.cmp = C_NE;  end
            OP_BEQ:  begin dec_o.kind = K_COND; dec_o.cmp = C_EQ;  end
            OP_BGEU: begin dec_o.kind = K_COND; dec_o.cmp = C_GEU; end
            OP_BLTU: begin dec_o.kind = K_COND; dec_o.cmp = C_LTU; end
            OP_RTYPE: begin
                case (xop_i)
                    XOP_RET:  dec_o.kind = K_RET;
                    XOP_JMPR: dec_o.kind = K_REG;
                    XOP_CALR: begin
                        dec_o.kind     = K_REG;
                        dec_o.link     = 1'b1;
                        dec_o.link_idx = LINK_REG;
                    end
                    XOP_RDPC: begin
                        dec_o.link     = 1'b1;
                        dec_o.link_idx = c_i;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctl_cond.sv
module ctl_cond
    import ctl_xfer_pkg::*;
(
    input  cmp_sel_e          sel_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic              taken_o
);

    logic eq, lt_s, lt_u;

    assign eq   = (a_i == b_i);
    assign lt_s = ($signed(a_i) < $signed(b_i));
    assign lt_u = (a_i < b_i);

    always_comb begin
        case (sel_i)
            C_GE:    taken_o = ~lt_s;
            C_LT:    taken_o = lt_s;
            C_NE:    taken_o = ~eq;
            C_EQ:    taken_o = eq;
            C_GEU:   taken_o = ~lt_u;
            C_LTU:   taken_o = lt_u;
            default: taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctl_target.sv
module ctl_target
    import ctl_xfer_pkg::*;
(
    input  logic [WORD_W-1:0]  pc_i,
    input  logic [IMM16_W-1:0] imm16_i,
    input  logic [IMM26_W-1:0] imm26_i,
    output logic [WORD_W-1:0]  seq_o,
    output logic [WORD_W-1:0]  abs_o,
    output logic [WORD_W-1:0]  rel_o
);

    localparam int EXT_W = WORD_W - IMM16_W;

    logic [WORD_W-1:0] offs;

    assign offs  = {{EXT_W{imm16_i[IMM16_W-1]}}, imm16_i[IMM16_W-1:2], 2'b00};
    assign seq_o = pc_i + WORD_W'(4);
    assign abs_o = {pc_i[WORD_W-1 -: REGION_W], imm26_i, 2'b00};
    assign rel_o = seq_o + offs;

endmodule

// File: rtl/ctl_xfer_unit.sv
module ctl_xfer_unit
    import ctl_xfer_pkg::*;
#(
    parameter logic [31:0] RESET_ADDR = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [31:0]       instr_i,
    input  logic [31:0]       ra_val_i,
    input  logic [31:0]       rb_val_i,
    input  logic [31:0]       r31_val_i,
    output logic [31:0]       pc_o,
    output logic              link_we_o,
    output logic [4:0]        link_idx_o,
    output logic [31:0]       link_val_o
);

    xfer_state_t       st_d, st_q;
    xfer_dec_t         dec;
    logic              taken;
    logic [WORD_W-1:0] seq_t, abs_t, rel_t;

    ctl_decode i_dec (
        .op_i  (instr_i[5:0]),
        .xop_i (instr_i[16:11]),
        .c_i   (instr_i[21:17]),
        .dec_o (dec)
    );

    ctl_cond i_cond (
        .sel_i   (dec.cmp),
        .a_i     (ra_val_i),
        .b_i     (rb_val_i),
        .taken_o (taken)
    );

    ctl_target i_tgt (
        .pc_i    (st_q.pc),
        .imm16_i (instr_i[21:6]),
        .imm26_i (instr_i[31:6]),
        .seq_o   (seq_t),
        .abs_o   (abs_t),
        .rel_o   (rel_t)
    );

    always_comb begin
        st_d       = st_q;
        link_we_o  = 1'b0;
        link_idx_o = dec.link_idx;
        link_val_o = seq_t;
        if (valid_i) begin
            link_we_o = dec.link && (dec.link_idx != '0);
            case (dec.kind)
                K_ABS:   st_d.pc = abs_t;
                K_REL:   st_d.pc = rel_t;
                K_COND:  st_d.pc = taken ? rel_t : seq_t;
                K_RET:   st_d.pc = r31_val_i;
                K_REG:   st_d.pc = ra_val_i;
                default: st_d.pc = seq_t;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc <= RESET_ADDR;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

endmodule

// File: rtl/ctl_xfer_chk.sv
module ctl_xfer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [31:0] instr_i,
    input logic [31:0] pc_o,
    input logic        link_we_o,
    input logic [4:0]  link_idx_o,
    input logic [31:0] link_val_o
);

    // R2
    idle_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(pc_o));

    // R2
    idle_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> !link_we_o);

    // R10
    no_zero_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_idx_o != 5'd0));

    // R5
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_val_o == pc_o + 32'd4));

    // R5
    call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[5:0] == 6'h00) |-> (link_we_o && link_idx_o == 5'd31));

    // R4
    region_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[5:0] == 6'h01) |=> (pc_o[31:28] == $past(pc_o[31:28])));

endmodule

bind ctl_xfer_unit ctl_xfer_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .instr_i    (instr_i),
    .pc_o       (pc_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o),
    .link_val_o (link_val_o)
);

// File: tb/test_ctl_xfer_unit.sv
`timescale 1ns/1ps
module test_ctl_xfer_unit;

    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] ra_val_i = '0;
    logic [31:0] rb_val_i = '0;
    logic [31:0] r31_val_i = '0;
    logic [31:0] pc_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_val_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] mdl_pc;

    always #2.5 clk = ~clk;

    ctl_xfer_unit #(.RESET_ADDR(RST_PC)) i_ctl_xfer_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .ra_val_i(ra_val_i), .rb_val_i(rb_val_i), .r31_val_i(r31_val_i),
        .pc_o(pc_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
        .link_val_o(link_val_o)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] a,
                                          input logic [4:0] b, input logic [15:0] imm);
        return {a, b, imm, op};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] imm);
        return {imm, op};
    endfunction

    function automatic logic [31:0] enc_r(input logic [5:0] xop, input logic [4:0] a,
                                          input logic [4:0] c);
        return {a, 5'd0, c, xop, 5'd0, 6'h3A};
    endfunction

    // Behavioural reference: next PC and expected link write
    task automatic model(input logic [31:0] pc, input logic v, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] r31,
                         output logic [31:0] npc, output logic we, output logic [4:0] idx);
        int  op, xop;
        logic [31:0] seq, br;
        bit  t;
        seq = pc + 4;
        br  = seq + ({{16{ins[21]}}, ins[21:6]} & 32'hFFFF_FFFC);
        npc = v ? seq : pc;
        we = 0; idx = 0;
        if (v) begin
            op = int'(ins[5:0]); xop = int'(ins[16:11]);
            t = 0;
            case (op)
                'h00: begin npc = {pc[31:28], ins[31:6], 2'b00}; we = 1; idx = 31; end
                'h01: npc = {pc[31:28], ins[31:6], 2'b00};
                'h06: npc = br;
                'h0E: t = $signed(a) >= $signed(b);
                'h16: t = $signed(a) <  $signed(b);
                'h1E: t = a != b;
                'h26: t = a == b;
                'h2E: t = a >= b;
                'h36: t = a <  b;
                'h3A: begin
                    if (xop == 'h05) npc = r31;
                    else if (xop == 'h0D) npc = a;
                    else if (xop == 'h1D) begin npc = a; we = 1; idx = 31; end
                    else if (xop == 'h1C) begin idx = ins[21:17]; we = (idx != 0); end
                end
                default: ;
            endcase
            if (t) npc = br;
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic v, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] r31);
        logic [31:0] npc; logic we; logic [4:0] idx;
        @(negedge clk);
        valid_i = v; instr_i = ins; ra_val_i = a; rb_val_i = b; r31_val_i = r31;
        model(mdl_pc, v, ins, a, b, r31, npc, we, idx);
        #1;
        check({req, " link"}, {link_we_o, (we ? {link_idx_o, link_val_o} : 37'd0)},
              {we, (we ? {idx, mdl_pc + 32'd4} : 37'd0)});
        @(posedge clk);
        mdl_pc = npc;
        #1;
        check({req, " pc"}, {32'd0, pc_o}, {32'd0, mdl_pc});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mdl_pc = RST_PC;
        #1;
        // R1 reset state
        check("R1 reset pc", {32'd0, pc_o}, {32'd0, RST_PC});
        check("R1 reset link", {63'd0, link_we_o}, 64'd0);

        // R2 idle with control instructions on the bus
        step("R2 idle call", 0, enc_j(6'h00, 26'h123), 0, 0, 0);
        step("R2 idle jmp", 0, enc_r(6'h0D, 5'd3, 5'd0), 32'h5555_0000, 0, 0);
        // R3 non-control
        step("R3 addi", 1, enc_i(6'h04, 5'd1, 5'd2, 16'h7FFF), 0, 0, 0);
        step("R3 stw", 1, enc_i(6'h15, 5'd1, 5'd2, 16'h0004), 0, 0, 0);
        // R8 register jump into a high region
        step("R8 jmp", 1, enc_r(6'h0D, 5'd4, 5'd0), 32'hA000_0010, 0, 0);
        // R4 region-relative jump and call
        step("R4 jump", 1, enc_j(6'h01, 26'h3FF_FFFF), 0, 0, 0);
        step("R5 call", 1, enc_j(6'h00, 26'h000_0040), 0, 0, 0);
        // R6 unconditional branch, low bits masked, both directions
        step("R6 br fwd", 1, enc_i(6'h06, 5'd0, 5'd0, 16'h0007), 0, 0, 0);
        step("R6 br back", 1, enc_i(6'h06, 5'd0, 5'd0, 16'hFFF6), 0, 0, 0);
        // R7 conditional branches, taken and not taken
        step("R7 bge s taken", 1, enc_i(6'h0E, 5'd1, 5'd2, 16'h0010), 32'd1, 32'hFFFF_FFFF, 0);
        step("R7 bge s not", 1, enc_i(6'h0E, 5'd1, 5'd2, 16'h0010), 32'hFFFF_FFFF, 32'd1, 0);
        step("R7 blt s taken", 1, enc_i(6'h16, 5'd1, 5'd2, 16'h0020), 32'hFFFF_FFFF, 32'd1, 0);
        step("R7 bltu not", 1, enc_i(6'h36, 5'd1, 5'd2, 16'h0020), 32'hFFFF_FFFF, 32'd1, 0);
        step("R7 bltu taken", 1, enc_i(6'h36, 5'd1, 5'd2, 16'hFF00), 32'd1, 32'hFFFF_FFFF, 0);
        step("R7 bgeu taken", 1, enc_i(6'h2E, 5'd1, 5'd2, 16'h0008), 32'hFFFF_FFFF, 32'd1, 0);
        step("R7 bgeu equal", 1, enc_i(6'h2E, 5'd1, 5'd2, 16'h0008), 32'd7, 32'd7, 0);
        step("R7 bge equal", 1, enc_i(6'h0E, 5'd1, 5'd2, 16'h0008), 32'd7, 32'd7, 0);
        step("R7 beq taken", 1, enc_i(6'h26, 5'd1, 5'd2, 16'h0100), 32'd9, 32'd9, 0);
        step("R7 beq not", 1, enc_i(6'h26, 5'd1, 5'd2, 16'h0100), 32'd9, 32'd8, 0);
        step("R7 bne taken", 1, enc_i(6'h1E, 5'd1, 5'd2, 16'hFFFC), 32'd9, 32'd8, 0);
        step("R7 bne not", 1, enc_i(6'h1E, 5'd1, 5'd2, 16'hFFFC), 32'd9, 32'd9, 0);
        // R8 return
        step("R8 ret", 1, enc_r(6'h05, 5'd31, 5'd0), 32'h1111_1110, 0, 32'h0000_2000);
        // R9 register call with A = 31 uses old value
        step("R9 callr a31", 1, enc_r(6'h1D, 5'd31, 5'd0), 32'h0000_3000, 0, 32'h0000_3000);
        step("R9 callr", 1, enc_r(6'h1D, 5'd7, 5'd0), 32'h0000_4400, 0, 32'h0);
        // R10 next-PC read
        step("R10 nextpc c5", 1, enc_r(6'h1C, 5'd0, 5'd5), 0, 0, 0);
        step("R10 nextpc c0", 1, enc_r(6'h1C, 5'd0, 5'd0), 0, 0, 0);
        // R11 other extended opcodes
        step("R11 add", 1, enc_r(6'h31, 5'd2, 5'd3), 32'h0000_9000, 0, 0);
        step("R11 eret", 1, enc_r(6'h01, 5'd29, 5'd0), 32'h0000_9000, 0, 32'h0000_9000);
        // R2 idle after activity
        step("R2 idle end", 0, enc_i(6'h06, 5'd0, 5'd0, 16'h0040), 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule